// File: doc/BRIEF.md
# Self-Starting Maximal-Length Sequence Generator

This block is a shift register whose first stage is fed by the XOR of chosen later stages. With the right taps it steps through every nonzero pattern of its width before it repeats. The result is a pseudo-random serial bit stream with a period of 2^N − 1 clocks. The default is N = 3 with taps on stages 2 and 3, which gives a seven-clock period.

The all-zero pattern maps onto itself under XOR feedback, so a plain register would stay stuck there. A small guard detects that pattern. On the next enabled edge it loads a fixed nonzero seed instead of shifting, so the generator starts from any state, including the state that reset leaves. The user drives `en` to advance the sequence. The serial stream is taken from the last stage, and the whole state is also brought out.

Top module: `mlsg_top`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the state is cleared to all zeros on that edge, whatever `en` is, and `sout` reads 0.
- R2: When `en` is low at a rising edge and `rst` is low, the state does not change.
- R3: When `en` is high and the state is all zeros, the next edge loads the seed, in which only stage 1 is set (`state` = 3'b001 for N = 3; bit 0 is stage 1).
- R4: When `en` is high and the state is nonzero, each stage k+1 takes the value of stage k (bit i takes bit i−1), and stage 1 takes the XOR of the tapped stages. The default taps are stages 2 and 3 (bits 1 and 2).
- R5: Starting from the seed, the default generator visits 001, 010, 101, 011, 111, 110, 100 in that order and returns to 001 after seven enabled edges. Each nonzero state appears exactly once per period.
- R6: `sout` always equals the last stage, bit N−1 of `state`.
- R7: Once the state is nonzero, enabled shifting never produces the all-zero state.
- R8: Recovery from all zeros takes a single enabled edge, and that edge leaves a nonzero state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high clear to all zeros |
| en | input | 1 | Advance enable |
| sout | output | 1 | Serial output, the last stage |
| state | output | N | Register contents, bit 0 = stage 1 |

## Verification
Once the generator runs, it never passes through the all-zero state, so the guard cannot be reached from the sequence itself. The bench reaches it with reset, which is the only way into zero. It then applies a single enabled edge and checks that the seed appears right away. The bench also asserts reset in the middle of a running period with `en` still high. It then confirms that recovery restarts the sequence from the seed.

// File: rtl/mlsg_pkg.sv
package mlsg_pkg;
    localparam int unsigned DEF_WIDTH = 3;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_SEED  = 2'd2,
        ACT_SHIFT = 2'd3
    } mlsg_act_e;

    function automatic mlsg_act_e pick_action(input logic rst, input logic en,
                                              input logic is_zero);
        if (rst)          return ACT_CLEAR;
        else if (!en)     return ACT_HOLD;
        else if (is_zero) return ACT_SEED;
        else              return ACT_SHIFT;
    endfunction
endpackage

// File: rtl/mlsg_feedback.sv
module mlsg_feedback #(
    parameter int unsigned N = 3,
    parameter logic [N-1:0] TAPS = 3'b110
) (
    input  logic [N-1:0] cur,
    output logic         fb
);
    logic [N-1:0] partial;

    for (genvar i = 0; i < N; i++) begin : g_tap
        if (i == 0) begin : g_first
            assign partial[i] = TAPS[i] & cur[i];
        end else begin : g_rest
            assign partial[i] = partial[i-1] ^ (TAPS[i] & cur[i]);
        end
    end

    assign fb = partial[N-1];
endmodule

// File: rtl/mlsg_zero_guard.sv
module mlsg_zero_guard #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] cur,
    output logic         is_zero
);
    assign is_zero = (cur == '0);
endmodule

// File: rtl/mlsg_top.sv
module mlsg_top #(
    parameter int unsigned N = mlsg_pkg::DEF_WIDTH,
    parameter logic [N-1:0] TAPS = 3'b110,
    parameter logic [N-1:0] SEED = 3'b001
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic         sout,
    output logic [N-1:0] state
);
    import mlsg_pkg::*;

    logic [N-1:0] q;
    logic [N-1:0] shifted;
    logic         fb;
    logic         is_zero;
    mlsg_act_e    act;

    mlsg_feedback #(.N(N), .TAPS(TAPS)) fb_i (.cur(q), .fb(fb));
    mlsg_zero_guard #(.N(N)) zg_i (.cur(q), .is_zero(is_zero));

    assign shifted = {q[N-2:0], fb};
    assign act     = pick_action(rst, en, is_zero);

    always_ff @(posedge clk) begin
        case (act)
            ACT_CLEAR: q <= '0;
            ACT_SEED:  q <= SEED;
            ACT_SHIFT: q <= shifted;
            default:   q <= q;
        endcase
    end

    assign state = q;
    assign sout  = q[N-1];
endmodule

// File: rtl/mlsg_checker.sv
module mlsg_checker #(
    parameter int unsigned N = 3,
    parameter logic [N-1:0] SEED = 3'b001
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         sout,
    input logic [N-1:0] state
);
    logic seen_rst = 1'b0;
    always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

    p_hold_r2: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        !en |=> $stable(state));

    p_seed_r3: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (en && state == '0) |=> (state == SEED));

    p_shift_r4: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (en && state != '0) |=> (state[N-1:1] == $past(state[N-2:0])));

    p_nonzero_r7: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (state != '0) |=> (state != '0));

    p_sout_r6: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        en |=> (sout == $past(state[N-2])) || $past(state == '0));
endmodule

bind mlsg_top mlsg_checker #(.N(N), .SEED(SEED)) chk_i (
    .clk(clk), .rst(rst), .en(en), .sout(sout), .state(state));

// File: tb/mlsg_top_tb_top.sv
module mlsg_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic       sout;
    logic [2:0] state;
    int         n_checks = 0;
    int         n_fail   = 0;
    bit         done     = 1'b0;

    always #2 clk = ~clk;

    mlsg_top dut_i (.clk(clk), .rst(rst), .en(en), .sout(sout), .state(state));

    logic [2:0] seq [7] = '{3'b001, 3'b010, 3'b101, 3'b011, 3'b111, 3'b110, 3'b100};

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 1'b1;
        step();
        check("R1 state", state, 3'b000);
        check("R1 sout", {2'b0, sout}, 3'b000);
        rst = 1'b0; en = 1'b0;
    endtask

    task automatic t_hold_zero();
        en = 1'b0;
        repeat (3) step();
        check("R2 hold at zero", state, 3'b000);
    endtask

    task automatic t_seed();
        en = 1'b1;
        step();
        check("R3 seed", state, 3'b001);
        check("R8 one edge nonzero", {2'b0, state != 3'b000}, 3'b001);
    endtask

    task automatic t_period();
        bit [7:0] seen = '0;
        en = 1'b1;
        for (int k = 1; k <= 14; k++) begin
            step();
            check("R4 R5 sequence", state, seq[k % 7]);
            check("R6 sout", {2'b0, sout}, {2'b0, seq[k % 7][2]});
            if (k <= 7) seen[state] = 1'b1;
            if (state == 3'b000) check("R7 nonzero", state, 3'b111);
        end
        check("R5 all nonzero once", {2'b0, seen == 8'hFE}, 3'b001);
    endtask

    task automatic t_hold_mid();
        logic [2:0] snap;
        en = 1'b1;
        step(); step();
        snap = state;
        en = 1'b0;
        repeat (4) step();
        check("R2 hold mid", state, snap);
        en = 1'b1;
        step();
        check("R4 resume", state, {snap[1:0], snap[1] ^ snap[2]});
    endtask

    task automatic t_reset_mid();
        en = 1'b1;
        step(); step();
        rst = 1'b1;
        step();
        check("R1 reset over en", state, 3'b000);
        rst = 1'b0;
        step();
        check("R3 R8 recovery", state, 3'b001);
        step();
        check("R5 restart", state, 3'b010);
    endtask

    initial begin
        #1;
        t_reset();
        t_hold_zero();
        t_seed();
        t_period();
        t_hold_mid();
        t_reset_mid();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule